// File: doc/BRIEF.md
# Register-Indirect Jump-and-Link Unit

This block executes a jump-and-link instruction whose target is taken from a base register rather than from the program counter. It sits in a short in-order pipeline slice with execute (E), memory (M) and writeback (W) stages. In E it decodes the instruction word and returns the base register index for the register file read. It adds the scaled, sign-extended offset to the base value, raises a one-cycle redirect toward fetch, and forms the link value, which is the PC of the jump plus four.

The link value is registered into M. There it competes with load data and the ALU result for the destination-register write. The M-stage write enable merges the regular register-file enable, the load enable and the link enable, and one flop turns it into the W-stage enable. The instruction fetched behind a taken jump is squashed. It is ignored in E, and it cannot raise the write enable when it reaches M.

Top module: `jmplink_unit`

## Requirements
- R1: An instruction is recognised as the jump only when `exValid` is high and bits [31:26] equal 6'b010011. Any other opcode never raises `redirect`.
- R2: `redirectTarget` equals `baseVal` plus the signed 16-bit offset in bits [25:10], shifted left by 2, with the sum wrapping at `DATA_W` bits. `baseIdx` equals bits [9:5].
- R3: `redirect` is high only in the E cycle of a recognised jump. A jump that sits in E in the very next cycle is ignored and produces no redirect.
- R4: In the cycle after a jump, `rdDataM` equals the jump's PC plus 4, unless load data is valid.
- R5: In the cycle after a jump whose bits [4:0] are non-zero, `linkWenM` is high and `linkRdM` equals bits [4:0].
- R6: A jump with destination 0 leaves `linkWenM` low. It does not raise `wenW`, and `rdDataM` falls back to the ALU result.
- R7: The M-stage data select gives load data first when `loadValidM` is high, then the link value when `linkWenM` is high, and otherwise `aluResM`.
- R8: The M-stage write enable is `rfWenM`, or `loadWenM` with `loadValidM`, or `linkWenM`. `loadWenM` alone has no effect.
- R9: `wenW` is the M-stage write enable delayed by exactly one clock.
- R10: Two cycles after a redirect, the squashed instruction reaches M. Its enables are ignored, so `wenW` stays low in the following cycle.
- R11: After reset, `redirect`, `linkWenM` and `wenW` are low and no squash is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| exValid | input | 1 | Instruction word in E is valid |
| exInstr | input | 32 | Instruction word in E |
| exPc | input | DATA_W | Address of the instruction in E |
| baseVal | input | DATA_W | Value of the base register named by `baseIdx` |
| baseIdx | output | 5 | Base register index decoded from E |
| redirect | output | 1 | Fetch redirect, one cycle in E |
| redirectTarget | output | DATA_W | Jump target address |
| aluResM | input | DATA_W | ALU result of the instruction in M |
| rfWenM | input | 1 | Regular register-file write enable in M |
| loadWenM | input | 1 | Load write enable in M |
| loadValidM | input | 1 | Load data valid in M |
| loadDataM | input | DATA_W | Load data in M |
| linkWenM | output | 1 | Link write enable in M |
| linkRdM | output | 5 | Link destination index in M |
| rdDataM | output | DATA_W | Selected destination write data in M |
| wenW | output | 1 | Register-file write enable in W |

## Verification
The assertions assume that `loadValidM` and the jump's link enable belong to one instruction in M, so that they describe the same slot. They also assume that the base value arrives in the same cycle as the instruction that names it. The bench drives every input just after the falling edge. It presents one instruction per stage per cycle and never overlaps a load-valid with a jump unless it is testing the select priority. Hazards and forwarding are outside the block, so the bench always supplies the correct base value directly.

// File: rtl/jmplink_pkg.sv
package jmplink_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_AW    = 5;
  localparam int OPC_W     = 6;
  localparam int OFF_W     = 16;
  localparam int OFF_SHIFT = 2;
  localparam int OPC_LSB   = 26;
  localparam int OFF_LSB   = 10;
  localparam int BASE_LSB  = 5;
  localparam int DEST_LSB  = 0;
  localparam logic [OPC_W-1:0] JUMP_OPC = 6'b010011;

  typedef struct packed {
    logic capture;
    logic selLoad;
    logic selLink;
  } dpStrobes_t;
endpackage

// File: rtl/jmplink_ctrl.sv
module jmplink_ctrl
  import jmplink_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              exValid,
  input  logic [OPC_W-1:0]  opcE,
  input  logic [REG_AW-1:0] destE,
  input  logic              rfWenM,
  input  logic              loadWenM,
  input  logic              loadValidM,
  output logic              redirect,
  output logic              linkWenM,
  output logic [REG_AW-1:0] linkRdM,
  output logic              wenW,
  output dpStrobes_t        strb
);
  logic jumpE;
  logic killE;
  logic killM;
  logic wenM;

  // decode: the slot right behind a taken jump is ignored
  assign jumpE    = exValid && (opcE == JUMP_OPC) && !killE;
  assign redirect = jumpE;

  assign wenM = (rfWenM || (loadWenM && loadValidM) || linkWenM) && !killM;

  assign strb.capture = jumpE;
  assign strb.selLoad = loadValidM;
  assign strb.selLink = linkWenM;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      killE    <= 1'b0;
      killM    <= 1'b0;
      linkWenM <= 1'b0;
      linkRdM  <= '0;
      wenW     <= 1'b0;
    end else begin
      killE    <= jumpE;
      killM    <= killE;
      linkWenM <= jumpE && (destE != '0);
      linkRdM  <= destE;
      wenW     <= wenM;
    end
  end

  // R3: redirect lasts one cycle
  a_r3_single_redirect: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);

  // R5: non-zero destination raises the link enable in M
  a_r5_link_enable: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && destE != '0) |=> (linkWenM && linkRdM == $past(destE)));

  // R6: destination zero is never written by the link
  a_r6_zero_dest: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && destE == '0) |=> !linkWenM);

  // R8: a qualified load enable reaches W
  a_r8_load_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!killM && loadWenM && loadValidM) |=> wenW);

  // R10: the squashed slot never writes
  a_r10_squash_quiet: assert property (@(posedge clk) disable iff (!rstN)
    killM |=> !wenW);
endmodule

// File: rtl/jmplink_dp.sv
module jmplink_dp
  import jmplink_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [OFF_W-1:0]  offE,
  input  logic [DATA_W-1:0] exPc,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] aluResM,
  input  logic [DATA_W-1:0] loadDataM,
  output logic [DATA_W-1:0] redirectTarget,
  output logic [DATA_W-1:0] rdDataM
);
  localparam int EXT_W = DATA_W - OFF_W - OFF_SHIFT;

  logic [DATA_W-1:0] offExt;
  logic [DATA_W-1:0] linkE;
  logic [DATA_W-1:0] linkM;

  assign offExt         = {{EXT_W{offE[OFF_W-1]}}, offE, {OFF_SHIFT{1'b0}}};
  assign redirectTarget = baseVal + offExt;
  assign linkE          = exPc + DATA_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (!rstN)             linkM <= '0;
    else if (strb.capture) linkM <= linkE;
  end

  // result select: load claims first, then link, ALU by default
  always_comb begin
    if (strb.selLoad)      rdDataM = loadDataM;
    else if (strb.selLink) rdDataM = linkM;
    else                   rdDataM = aluResM;
  end

  // R4: link reaches M as PC plus step
  a_r4_link_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture ##1 (strb.selLink && !strb.selLoad)
      |-> rdDataM == $past(exPc) + DATA_W'(PC_STEP));

  // R7: valid load data always wins the select
  a_r7_load_first: assert property (@(posedge clk) disable iff (!rstN)
    strb.selLoad |-> rdDataM == loadDataM);
endmodule

// File: rtl/jmplink_unit.sv
module jmplink_unit
  import jmplink_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               exValid,
  input  logic [INSTR_W-1:0] exInstr,
  input  logic [DATA_W-1:0]  exPc,
  input  logic [DATA_W-1:0]  baseVal,
  output logic [REG_AW-1:0]  baseIdx,
  output logic               redirect,
  output logic [DATA_W-1:0]  redirectTarget,
  input  logic [DATA_W-1:0]  aluResM,
  input  logic               rfWenM,
  input  logic               loadWenM,
  input  logic               loadValidM,
  input  logic [DATA_W-1:0]  loadDataM,
  output logic               linkWenM,
  output logic [REG_AW-1:0]  linkRdM,
  output logic [DATA_W-1:0]  rdDataM,
  output logic               wenW
);
  dpStrobes_t strb;

  assign baseIdx = exInstr[BASE_LSB +: REG_AW];

  jmplink_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .exValid    (exValid),
    .opcE       (exInstr[OPC_LSB +: OPC_W]),
    .destE      (exInstr[DEST_LSB +: REG_AW]),
    .rfWenM     (rfWenM),
    .loadWenM   (loadWenM),
    .loadValidM (loadValidM),
    .redirect   (redirect),
    .linkWenM   (linkWenM),
    .linkRdM    (linkRdM),
    .wenW       (wenW),
    .strb       (strb)
  );

  jmplink_dp #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .offE           (exInstr[OFF_LSB +: OFF_W]),
    .exPc           (exPc),
    .baseVal        (baseVal),
    .aluResM        (aluResM),
    .loadDataM      (loadDataM),
    .redirectTarget (redirectTarget),
    .rdDataM        (rdDataM)
  );
endmodule

// File: tb/jmplink_unit_tb_top.sv
`timescale 1ns/100ps
module jmplink_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        exValid;
  logic [31:0] exInstr;
  logic [31:0] exPc;
  logic [31:0] baseVal;
  logic [4:0]  baseIdx;
  logic        redirect;
  logic [31:0] redirectTarget;
  logic [31:0] aluResM;
  logic        rfWenM;
  logic        loadWenM;
  logic        loadValidM;
  logic [31:0] loadDataM;
  logic        linkWenM;
  logic [4:0]  linkRdM;
  logic [31:0] rdDataM;
  logic        wenW;

  int testsRun  = 0;
  int testsFail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  jmplink_unit dut_i (
    .clk(clk), .rstN(rstN), .exValid(exValid), .exInstr(exInstr), .exPc(exPc),
    .baseVal(baseVal), .baseIdx(baseIdx), .redirect(redirect),
    .redirectTarget(redirectTarget), .aluResM(aluResM), .rfWenM(rfWenM),
    .loadWenM(loadWenM), .loadValidM(loadValidM), .loadDataM(loadDataM),
    .linkWenM(linkWenM), .linkRdM(linkRdM), .rdDataM(rdDataM), .wenW(wenW)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] mkJump(logic [4:0] rd, logic [4:0] rj, logic [15:0] off);
    return {6'b010011, off, rj, rd};
  endfunction

  function automatic logic [31:0] expTarget(logic [31:0] b, logic [15:0] off);
    return b + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    exValid = 0; exInstr = 0; exPc = 0; baseVal = 0;
    rfWenM = 0; loadWenM = 0; loadValidM = 0;
    aluResM = 32'hA1A1_0000; loadDataM = 32'h10AD_0000;
  endtask

  initial begin
    #(200000 * 5);
    testsFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #0.5;
    check(wenW == 0, "R11 wenW", 32'(wenW), 0);
    check(linkWenM == 0, "R11 linkWenM", 32'(linkWenM), 0);
    check(redirect == 0, "R11 redirect", 32'(redirect), 0);

    // worked example: base 0x1C000000, offset 0x18, jump at 0x1C000010 to r1
    exValid = 1; exInstr = 32'h4c0018c1; exPc = 32'h1C000010; baseVal = 32'h1C000000;
    #0.5;
    check(redirect == 1, "R1 example redirect", 32'(redirect), 1);
    check(redirectTarget == 32'h1C000018, "R2 example target", redirectTarget, 32'h1C000018);
    check(baseIdx == 5'd6, "R2 example baseIdx", 32'(baseIdx), 6);
    step();
    // shadow slot holds another jump; it must be ignored
    exValid = 1; exInstr = mkJump(5'd2, 5'd6, 16'h0040); exPc = 32'h1C000014;
    aluResM = 32'hDEAD_BEEF;
    #0.5;
    check(redirect == 0, "R3 shadow ignored", 32'(redirect), 0);
    check(linkWenM == 1, "R5 example linkWenM", 32'(linkWenM), 1);
    check(linkRdM == 5'd1, "R5 example linkRdM", 32'(linkRdM), 1);
    check(rdDataM == 32'h1C000014, "R4 example link", rdDataM, 32'h1C000014);
    step();
    idle();
    rfWenM = 1; loadWenM = 1; loadValidM = 1;
    #0.5;
    check(wenW == 1, "R9 example wenW", 32'(wenW), 1);
    step();
    idle();
    #0.5;
    check(wenW == 0, "R10 shadow no retire", 32'(wenW), 0);
    step();

    // jump sweep with random bases, offsets and destinations
    for (int i = 0; i < 300; i++) begin
      logic [4:0]  rd, rj;
      logic [15:0] off;
      logic [31:0] pc, b, alu, other;
      rd = (i % 17 == 0) ? 5'd0 : rnd()[4:0];
      rj = rnd()[4:0];
      case (i % 6)
        0: off = 16'h7FFF;
        1: off = 16'h8000;
        2: off = 16'hFFFF;
        3: off = 16'h0000;
        default: off = rnd()[15:0];
      endcase
      pc = {rnd()[31:2], 2'b00};
      b = (i % 5 == 0) ? 32'hFFFF_FFF0 : rnd();
      exValid = 1; exInstr = mkJump(rd, rj, off); exPc = pc; baseVal = b;
      #0.5;
      check(redirect == 1, "R1 sweep redirect", 32'(redirect), 1);
      check(redirectTarget == expTarget(b, off), "R2 sweep target", redirectTarget, expTarget(b, off));
      check(baseIdx == rj, "R2 sweep baseIdx", 32'(baseIdx), 32'(rj));
      step();
      idle();
      alu = rnd(); aluResM = alu;
      #0.5;
      check(linkWenM == (rd != 0), "R5 R6 sweep linkWenM", 32'(linkWenM), 32'(rd != 0));
      if (rd != 0) begin
        check(linkRdM == rd, "R5 sweep linkRdM", 32'(linkRdM), 32'(rd));
        check(rdDataM == pc + 4, "R4 sweep link", rdDataM, pc + 4);
      end else
        check(rdDataM == alu, "R6 sweep alu fallback", rdDataM, alu);
      step();
      idle();
      other = rnd();
      if (other[31:26] == 6'b010011) other[26] = ~other[26];
      exValid = 1; exInstr = other;
      #0.5;
      check(wenW == (rd != 0), "R6 R9 sweep wenW", 32'(wenW), 32'(rd != 0));
      check(redirect == 0, "R1 other opcode", 32'(redirect), 0);
      step();
    end

    // select and enable sweep without a link
    idle();
    step(); step();
    for (int c = 0; c < 8; c++) begin
      logic [31:0] alu, ld;
      alu = rnd(); ld = rnd();
      idle();
      rfWenM = c[0]; loadWenM = c[1]; loadValidM = c[2];
      aluResM = alu; loadDataM = ld;
      #0.5;
      check(rdDataM == (c[2] ? ld : alu), "R7 select no link", rdDataM, c[2] ? ld : alu);
      step();
      idle();
      #0.5;
      check(wenW == (c[0] | (c[1] & c[2])), "R8 enable merge", 32'(wenW), 32'(c[0] | (c[1] & c[2])));
    end

    // select with a link in M
    for (int c = 0; c < 8; c++) begin
      logic [31:0] alu, ld, pc;
      alu = rnd(); ld = rnd(); pc = {rnd()[31:2], 2'b00};
      idle();
      exValid = 1; exInstr = mkJump(5'd3, 5'd4, 16'h0010); exPc = pc; baseVal = rnd();
      step();
      idle();
      rfWenM = c[0]; loadWenM = c[1]; loadValidM = c[2];
      aluResM = alu; loadDataM = ld;
      #0.5;
      check(rdDataM == (c[2] ? ld : pc + 4), "R7 select with link", rdDataM, c[2] ? ld : pc + 4);
      step();
      idle();
      #0.5;
      check(wenW == 1, "R8 link enable", 32'(wenW), 1);
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule